// File: doc/BRIEF.md
# Prioritised Memory-Protection Permission Checker

This block decides whether a single memory access may proceed under a set of protection entries. Each entry supplies an inclusive start and end address plus one configuration byte holding read, write and execute grants, an address-match enable field and a lock bit. The access supplies its first address, its size in bytes, the set of permissions it needs and whether it runs in machine mode. Two security-control bits, a lockdown bit and a whitelist bit, select between the classic permission rule and a stricter lockdown rule. They also shape the policy applied when no entry matches.

Entries are scanned from index 0 upwards. An access that straddles an entry boundary is refused on the spot. The first enabled entry that holds the whole access supplies the granted set. With no such entry, a default policy applies. The result is purely combinational, so an address-translation or load/store pipeline can use it in the same cycle it presents the request. Register writes and the decoding of entry bounds sit outside this block; it receives bounds already decoded.

Top module: `pmp_perm_check`

## Requirements
- R1: The last byte of an access is `acc_addr + size - 1`, computed modulo 2^ADDR_W. A `acc_size` of 0 counts as 4 bytes.
- R2: When entries are scanned from index 0 upwards and an entry (enabled or not) holds exactly one of the first and last bytes before any deciding entry is reached, the access fails with `grant_perm` = 0.
- R3: The first entry whose match field (cfg bits 4:3) is nonzero and whose inclusive range holds both bytes decides the result. Entries with a zero match field are skipped.
- R4: Permissions are encoded as bit 0 = read, bit 1 = write, bit 2 = execute, both in `acc_perm` and `grant_perm` and in cfg bits 2:0. When an entry decides, `grant_ok` is 1 exactly when every requested bit is present in `grant_perm`.
- R5: With lockdown clear, a machine-mode access decided by an entry whose lock bit (cfg bit 7) is 0 is granted read, write and execute. Every other access decided by an entry is granted that entry's cfg bits 2:0.
- R6: With lockdown set, machine-mode accesses look up the index {lock, R, W, X}. Indices 0, 1 and 4 to 8 grant none; 2, 3 and 14 grant RW; 9 and 10 grant X; 11 and 13 grant RX; 12 and 15 grant R.
- R7: With lockdown set, lower-mode accesses use the same index. Indices 0, 8, 9, 12, 13 and 14 grant none; 1, 10 and 11 grant X; 2, 4 and 15 grant R; 3 and 6 grant RW; 5 grants RX; 7 grants RWX.
- R8: With no deciding entry and the whitelist bit set, the access fails with nothing granted, whatever the mode.
- R9: With no deciding entry, the whitelist bit clear and lockdown set, a machine-mode access that does not request execute passes with RW. Any other access fails with nothing granted.
- R10: With no deciding entry and both security bits clear, machine mode passes with RWX and lower modes fail with nothing granted. A failing default never passes, even for an empty request.
- R11: When every entry has a zero match field, the default policy applies directly and straddled boundaries have no effect.
- R12: `grant_perm` and `grant_ok` depend only on the present inputs and settle within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_size | input | SIZE_W | Access size in bytes, 0 meaning 4 |
| acc_perm | input | 3 | Requested permissions {X, W, R} |
| acc_mmode | input | 1 | 1 when the access runs in machine mode |
| ent_lo | input | N_ENT*ADDR_W | Inclusive start address of each entry, entry i at bits i*ADDR_W upwards |
| ent_hi | input | N_ENT*ADDR_W | Inclusive end address of each entry |
| ent_cfg | input | N_ENT*8 | Configuration byte per entry: bits 2:0 RWX, bits 4:3 match enable, bit 7 lock |
| sec_lockdown | input | 1 | Selects the lockdown permission tables and default |
| sec_whitelist | input | 1 | Denies every access that no entry decides |
| grant_perm | output | 3 | Granted permission set {X, W, R} |
| grant_ok | output | 1 | 1 when the access may proceed |

## Verification
The embedded assertions watch on every evaluation that a passing access never asks for more than it was granted. They also check that a straddled boundary always fails, that the whitelist default denies everything, and that the lower-mode default denies. They further check that at most one entry is ever selected and that lockdown never hands machine mode full RWX. Only the bench scenarios can show that the right entry wins the priority scan and that a disabled entry still causes a straddle failure. The same holds for the zero-size rule and for every index of both lockdown tables, which the bench sweeps against its own model.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    localparam int PERM_W   = 3;
    localparam int CFG_W    = 8;
    localparam int CFG_R    = 0;
    localparam int CFG_W_B  = 1;
    localparam int CFG_X    = 2;
    localparam int CFG_A_LO = 3;
    localparam int CFG_A_HI = 4;
    localparam int CFG_L    = 7;
    localparam int DEF_BYTES = 4;

    typedef logic [PERM_W-1:0] perm_t;

    localparam perm_t PERM_NONE = 3'b000;
    localparam perm_t PERM_R    = 3'b001;
    localparam perm_t PERM_X    = 3'b100;
    localparam perm_t PERM_RW   = 3'b011;
    localparam perm_t PERM_RX   = 3'b101;
    localparam perm_t PERM_RWX  = 3'b111;

    typedef struct packed {
        perm_t allowed;
        logic  pass;
    } verdict_t;

endpackage

// File: rtl/pmp_range_cmp.sv
module pmp_range_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              in_first,
    output logic              in_last
);
    always_comb begin
        in_first = (first_addr >= lo) && (first_addr <= hi);
        in_last  = (last_addr  >= lo) && (last_addr  <= hi);
    end
endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
    parameter int N_ENT = 8
) (
    input  logic [N_ENT-1:0] in_first,
    input  logic [N_ENT-1:0] in_last,
    input  logic [N_ENT-1:0] active,
    output logic             any_active,
    output logic             part_hit,
    output logic             full_hit,
    output logic [N_ENT-1:0] sel
);
    logic found;

    always_comb begin
        found    = 1'b0;
        part_hit = 1'b0;
        full_hit = 1'b0;
        sel      = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!found) begin
                if (in_first[i] ^ in_last[i]) begin
                    found    = 1'b1;
                    part_hit = 1'b1;
                end else if (in_first[i] && in_last[i] && active[i]) begin
                    found    = 1'b1;
                    full_hit = 1'b1;
                    sel[i]   = 1'b1;
                end
            end
        end
        any_active = |active;
    end

    // R3: priority scan picks no more than one entry
    always_comb begin
        p_sel_onehot_r3: assert ($onehot0(sel))
            else $error("more than one entry selected");
    end
endmodule

// File: rtl/pmp_perm_lut.sv
module pmp_perm_lut
    import pmp_chk_pkg::*;
(
    input  logic [3:0] lrwx,
    input  logic       mmode,
    input  logic       lockdown,
    output perm_t      allowed
);
    always_comb begin
        allowed = PERM_NONE;
        if (!lockdown) begin
            if (mmode && !lrwx[3]) allowed = PERM_RWX;
            else                   allowed = {lrwx[0], lrwx[1], lrwx[2]};
        end else if (mmode) begin
            unique case (lrwx)
                4'd2, 4'd3, 4'd14:  allowed = PERM_RW;
                4'd9, 4'd10:        allowed = PERM_X;
                4'd11, 4'd13:       allowed = PERM_RX;
                4'd12, 4'd15:       allowed = PERM_R;
                default:            allowed = PERM_NONE;
            endcase
        end else begin
            unique case (lrwx)
                4'd1, 4'd10, 4'd11: allowed = PERM_X;
                4'd2, 4'd4, 4'd15:  allowed = PERM_R;
                4'd3, 4'd6:         allowed = PERM_RW;
                4'd5:               allowed = PERM_RX;
                4'd7:               allowed = PERM_RWX;
                default:            allowed = PERM_NONE;
            endcase
        end
    end

    // R6: lockdown never grants machine mode all three permissions
    always_comb begin
        if (lockdown && mmode) begin
            p_mm_no_rwx_r6: assert (allowed != PERM_RWX)
                else $error("lockdown granted RWX to machine mode");
        end
    end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
    import pmp_chk_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [SIZE_W-1:0]       acc_size,
    input  logic [2:0]              acc_perm,
    input  logic                    acc_mmode,
    input  logic [N_ENT*ADDR_W-1:0] ent_lo,
    input  logic [N_ENT*ADDR_W-1:0] ent_hi,
    input  logic [N_ENT*8-1:0]      ent_cfg,
    input  logic                    sec_lockdown,
    input  logic                    sec_whitelist,
    output logic [2:0]              grant_perm,
    output logic                    grant_ok
);
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] last_addr;
    logic [N_ENT-1:0]  in_first;
    logic [N_ENT-1:0]  in_last;
    logic [N_ENT-1:0]  active;
    logic [N_ENT-1:0]  sel;
    logic              any_active;
    logic              part_hit;
    logic              full_hit;
    logic [CFG_W-1:0]  sel_cfg;
    perm_t             lut_perm;
    verdict_t          verdict_d;
    logic              unused_cfg_bits;

    always_comb begin
        span      = (acc_size == '0) ? ADDR_W'(DEF_BYTES) : ADDR_W'(acc_size);
        last_addr = acc_addr + span - ADDR_W'(1);
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        pmp_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .first_addr (acc_addr),
            .last_addr  (last_addr),
            .lo         (ent_lo[g*ADDR_W +: ADDR_W]),
            .hi         (ent_hi[g*ADDR_W +: ADDR_W]),
            .in_first   (in_first[g]),
            .in_last    (in_last[g])
        );
        assign active[g] = |ent_cfg[g*CFG_W+CFG_A_LO +: 2];
    end

    pmp_prio_sel #(.N_ENT(N_ENT)) u_sel (
        .in_first   (in_first),
        .in_last    (in_last),
        .active     (active),
        .any_active (any_active),
        .part_hit   (part_hit),
        .full_hit   (full_hit),
        .sel        (sel)
    );

    always_comb begin
        sel_cfg = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (sel[i]) sel_cfg = sel_cfg | ent_cfg[i*CFG_W +: CFG_W];
        end
    end

    assign unused_cfg_bits = ^{sel_cfg[6:5], sel_cfg[CFG_A_HI:CFG_A_LO]};

    pmp_perm_lut u_lut (
        .lrwx     ({sel_cfg[CFG_L], sel_cfg[CFG_R], sel_cfg[CFG_W_B], sel_cfg[CFG_X]}),
        .mmode    (acc_mmode),
        .lockdown (sec_lockdown),
        .allowed  (lut_perm)
    );

    always_comb begin
        verdict_d = '{allowed: PERM_NONE, pass: 1'b0};
        if (any_active && part_hit) begin
            verdict_d = '{allowed: PERM_NONE, pass: 1'b0};
        end else if (any_active && full_hit) begin
            verdict_d.allowed = lut_perm;
            verdict_d.pass    = (acc_perm & ~lut_perm) == 3'b000;
        end else if (sec_whitelist) begin
            verdict_d = '{allowed: PERM_NONE, pass: 1'b0};
        end else if (sec_lockdown) begin
            if (acc_mmode && !acc_perm[CFG_X])
                verdict_d = '{allowed: PERM_RW, pass: 1'b1};
        end else if (acc_mmode) begin
            verdict_d = '{allowed: PERM_RWX, pass: 1'b1};
        end
    end

    assign grant_perm = verdict_d.allowed;
    assign grant_ok   = verdict_d.pass;

    always_comb begin
        // R4: a pass never exceeds the granted set
        if (grant_ok) begin
            p_pass_subset_r4: assert ((acc_perm & ~grant_perm) == 3'b000)
                else $error("pass with permission outside grant");
        end
        // R2: a straddled boundary always fails
        if (any_active && part_hit) begin
            p_partial_fail_r2: assert (!grant_ok && grant_perm == 3'b000)
                else $error("straddling access not refused");
        end
        // R8: whitelist default denies everything
        if (!(any_active && (part_hit || full_hit)) && sec_whitelist) begin
            p_wl_deny_r8: assert (!grant_ok && grant_perm == 3'b000)
                else $error("whitelist default did not deny");
        end
        // R10: lower-mode classic default denies
        if (!(any_active && (part_hit || full_hit)) && !sec_whitelist
            && !sec_lockdown && !acc_mmode) begin
            p_lower_deny_r10: assert (!grant_ok)
                else $error("lower-mode default passed");
        end
    end
endmodule

// File: tb/tb_pmp_perm_check.sv
module tb_pmp_perm_check;
    import pmp_chk_pkg::*;

    localparam int N  = 8;
    localparam int AW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0]   acc_addr;
    logic [SW-1:0]   acc_size;
    logic [2:0]      acc_perm;
    logic            acc_mmode;
    logic [N*AW-1:0] lo_bus;
    logic [N*AW-1:0] hi_bus;
    logic [N*8-1:0]  cfg_bus;
    logic            sec_lockdown;
    logic            sec_whitelist;
    logic [2:0]      grant_perm;
    logic            grant_ok;

    logic [AW-1:0] e_lo  [N];
    logic [AW-1:0] e_hi  [N];
    logic [7:0]    e_cfg [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            lo_bus[i*AW +: AW] = e_lo[i];
            hi_bus[i*AW +: AW] = e_hi[i];
            cfg_bus[i*8 +: 8]  = e_cfg[i];
        end
    end

    pmp_perm_check #(.N_ENT(N), .ADDR_W(AW), .SIZE_W(SW)) dut (
        .acc_addr      (acc_addr),
        .acc_size      (acc_size),
        .acc_perm      (acc_perm),
        .acc_mmode     (acc_mmode),
        .ent_lo        (lo_bus),
        .ent_hi        (hi_bus),
        .ent_cfg       (cfg_bus),
        .sec_lockdown  (sec_lockdown),
        .sec_whitelist (sec_whitelist),
        .grant_perm    (grant_perm),
        .grant_ok      (grant_ok)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [2:0] ea, input logic ep);
        n_chk++;
        if (grant_perm !== ea || grant_ok !== ep) begin
            n_fail++;
            $display("FAIL %s: got perm=%b ok=%b expected perm=%b ok=%b (addr=%h size=%0d req=%b m=%b)",
                     tag, grant_perm, grant_ok, ea, ep, acc_addr, acc_size, acc_perm, acc_mmode);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [3:0] sz, input logic [2:0] rq,
                         input logic mm, input logic lk, input logic wl);
        @(posedge clk);
        #1;
        acc_addr = a; acc_size = sz; acc_perm = rq;
        acc_mmode = mm; sec_lockdown = lk; sec_whitelist = wl;
        @(negedge clk);
    endtask

    function automatic logic [2:0] ld_table(input logic [3:0] idx, input logic mm);
        if (mm) begin
            case (idx)
                4'd2, 4'd3, 4'd14:  return 3'b011;
                4'd9, 4'd10:        return 3'b100;
                4'd11, 4'd13:       return 3'b101;
                4'd12, 4'd15:       return 3'b001;
                default:            return 3'b000;
            endcase
        end
        case (idx)
            4'd1, 4'd10, 4'd11: return 3'b100;
            4'd2, 4'd4, 4'd15:  return 3'b001;
            4'd3, 4'd6:         return 3'b011;
            4'd5:               return 3'b101;
            4'd7:               return 3'b111;
            default:            return 3'b000;
        endcase
    endfunction

    // returns {pass, allowed}
    function automatic logic [3:0] model(input logic [31:0] a, input logic [3:0] sz,
                                         input logic [2:0] rq, input logic mm,
                                         input logic lk, input logic wl);
        logic [31:0] last;
        logic on_any;
        logic s, e;
        logic [2:0] al;
        last = a + ((sz == 0) ? 32'd4 : 32'(sz)) - 32'd1;
        on_any = 1'b0;
        for (int i = 0; i < N; i++) if (e_cfg[i][4:3] != 2'b00) on_any = 1'b1;
        if (on_any) begin
            for (int i = 0; i < N; i++) begin
                s = (a >= e_lo[i]) && (a <= e_hi[i]);
                e = (last >= e_lo[i]) && (last <= e_hi[i]);
                if (s != e) return 4'b0000;
                if (s && e && e_cfg[i][4:3] != 2'b00) begin
                    if (!lk) al = (mm && !e_cfg[i][7]) ? 3'b111 : e_cfg[i][2:0];
                    else al = ld_table({e_cfg[i][7], e_cfg[i][0], e_cfg[i][1], e_cfg[i][2]}, mm);
                    return {((rq & ~al) == 3'b000), al};
                end
            end
        end
        if (wl) return 4'b0000;
        if (lk) return (mm && !rq[2]) ? 4'b1011 : 4'b0000;
        return mm ? 4'b1111 : 4'b0000;
    endfunction

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  size;
        logic [2:0]  perm;
        logic        mm;
        logic        lk;
        logic        wl;
        logic [2:0]  exp_perm;
        logic        exp_ok;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'h1010, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 8'd3},  // R3 entry 0 wins
        '{32'h1010, 4'd4, 3'b010, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 8'd4},  // R4 missing write
        '{32'h1010, 4'd4, 3'b010, 1'b1, 1'b0, 1'b0, 3'b111, 1'b1, 8'd5},  // R5 unlocked machine
        '{32'h10FC, 4'd8, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'd2},  // R2 straddle
        '{32'h1200, 4'd4, 3'b010, 1'b0, 1'b0, 1'b0, 3'b111, 1'b1, 8'd3},  // R3 entry 1
        '{32'h3010, 4'd0, 3'b100, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 8'd3},  // R3 skip off entry
        '{32'h3010, 4'd4, 3'b010, 1'b1, 1'b0, 1'b0, 3'b101, 1'b0, 8'd5},  // R5 locked machine
        '{32'h3FFE, 4'd0, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'd1},  // R1 size0 straddles off entry
        '{32'h3FFE, 4'd2, 3'b001, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 8'd1},  // R1 size2 fits
        '{32'h6000, 4'd4, 3'b001, 1'b1, 1'b0, 1'b0, 3'b111, 1'b1, 8'd10}, // R10 machine default
        '{32'h6000, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'd10}, // R10 lower default
        '{32'h6000, 4'd4, 3'b001, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, 8'd8},  // R8 whitelist
        '{32'h6000, 4'd4, 3'b001, 1'b1, 1'b1, 1'b0, 3'b011, 1'b1, 8'd9},  // R9 machine read
        '{32'h6000, 4'd4, 3'b100, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'd9},  // R9 machine exec
        '{32'h6000, 4'd4, 3'b010, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'd9},  // R9 lower
        '{32'h5000, 4'd4, 3'b010, 1'b0, 1'b1, 1'b0, 3'b001, 1'b0, 8'd7},  // R7 index 2 lower
        '{32'h5000, 4'd4, 3'b001, 1'b1, 1'b1, 1'b0, 3'b011, 1'b1, 8'd6},  // R6 index 2 machine
        '{32'h3010, 4'd4, 3'b001, 1'b1, 1'b1, 1'b0, 3'b101, 1'b1, 8'd6},  // R6 index 13 machine
        '{32'h3010, 4'd4, 3'b100, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'd7},  // R7 index 13 lower
        '{32'h1010, 4'd4, 3'b001, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, 8'd6},  // R6 match beats whitelist
        '{32'h6000, 4'd4, 3'b000, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'd10}  // R10 empty request
    };

    task automatic setup_main();
        for (int i = 0; i < N; i++) begin
            e_lo[i] = 32'hF000_0000; e_hi[i] = 32'hF000_000F; e_cfg[i] = 8'h00;
        end
        e_lo[0] = 32'h1000; e_hi[0] = 32'h10FF; e_cfg[0] = 8'h09;
        e_lo[1] = 32'h1000; e_hi[1] = 32'h1FFF; e_cfg[1] = 8'h0F;
        e_lo[2] = 32'h3000; e_hi[2] = 32'h3FFF; e_cfg[2] = 8'h07;
        e_lo[3] = 32'h3000; e_hi[3] = 32'h3FFF; e_cfg[3] = 8'h9D;
        e_lo[4] = 32'h5000; e_hi[4] = 32'h5003; e_cfg[4] = 8'h12;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [3:0] m;
        acc_addr = '0; acc_size = '0; acc_perm = '0; acc_mmode = 1'b0;
        sec_lockdown = 1'b0; sec_whitelist = 1'b0;
        for (int i = 0; i < N; i++) begin
            e_lo[i] = '0; e_hi[i] = '0; e_cfg[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset state lower default", 3'b000, 1'b0);

        setup_main();
        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].addr, VECS[v].size, VECS[v].perm, VECS[v].mm, VECS[v].lk, VECS[v].wl);
            chk($sformatf("R%0d vector %0d", VECS[v].req, v), VECS[v].exp_perm, VECS[v].exp_ok);
        end

        // R12: result available in the cycle the request is presented
        @(posedge clk);
        #1;
        acc_addr = 32'h1010; acc_size = 4'd4; acc_perm = 3'b001; acc_mmode = 1'b0;
        sec_lockdown = 1'b0; sec_whitelist = 1'b0;
        #2;
        chk("R12 same-cycle result", 3'b001, 1'b1);

        // R6 R7: sweep every lockdown index in both modes
        for (int k = 0; k < 16; k++) begin
            for (int md = 0; md < 2; md++) begin
                setup_main();
                e_cfg[0] = {k[3], 2'b00, 2'b01, k[0], k[1], k[2]};
                e_hi[0]  = 32'h1FFF;
                drive(32'h1100, 4'd4, 3'((k % 7) + 1), md[0], 1'b1, 1'b0);
                m = model(32'h1100, 4'd4, 3'((k % 7) + 1), md[0], 1'b1, 1'b0);
                chk(md[0] ? "R6 lockdown machine sweep" : "R7 lockdown lower sweep", m[2:0], m[3]);
            end
        end

        // R5: classic rule sweep over lock and RWX
        for (int k = 0; k < 16; k++) begin
            for (int md = 0; md < 2; md++) begin
                setup_main();
                e_cfg[0] = {k[3], 2'b00, 2'b01, k[2:0]};
                e_hi[0]  = 32'h1FFF;
                drive(32'h1100, 4'd4, 3'b111, md[0], 1'b0, 1'b0);
                m = model(32'h1100, 4'd4, 3'b111, md[0], 1'b0, 1'b0);
                chk("R5 classic sweep", m[2:0], m[3]);
            end
        end

        // R11: all entries disabled, straddle ignored
        setup_main();
        for (int i = 0; i < N; i++) e_cfg[i][4:3] = 2'b00;
        drive(32'h10FC, 4'd8, 3'b111, 1'b1, 1'b0, 1'b0);
        chk("R11 all-off machine", 3'b111, 1'b1);
        drive(32'h10FC, 4'd8, 3'b001, 1'b0, 1'b0, 1'b0);
        chk("R11 all-off lower", 3'b000, 1'b0);
        drive(32'h10FC, 4'd8, 3'b011, 1'b1, 1'b1, 1'b0);
        chk("R11 all-off lockdown", 3'b011, 1'b1);

        // R1: wrap of the last byte at the top of the address space
        setup_main();
        e_lo[5] = 32'hFFFF_FF00; e_hi[5] = 32'hFFFF_FFFF; e_cfg[5] = 8'h0B;
        drive(32'hFFFF_FFFE, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0);
        chk("R1 wrapped last byte straddles", 3'b000, 1'b0);
        drive(32'hFFFF_FFFC, 4'd0, 3'b010, 1'b0, 1'b0, 1'b0);
        chk("R1 size0 at top fits", 3'b011, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule